// File: doc/BRIEF.md
# Linear CCD Line Transfer Timing Generator

This block produces the digital drive pattern for a linear photodiode-array CCD sensor. It runs from one fast system clock and issues seven outputs: two complementary horizontal shift phases, a transfer gate, a photo gate, an anti-blooming gate, a per-pixel valid strobe and an end-of-line pulse. Every interval in the pattern is a cycle count of the system clock, supplied on input ports.

A line starts when the block is idle and sees a start request. The block captures all settings on that clock edge. The shift phases are already parked with phase 1 high and phase 2 low. The block then runs a fixed order of steps. First it waits a programmable lead time. It raises the transfer gate. After a further delay it pulses the photo gate. It lowers the transfer gate after a lag. After another delay it pulses the anti-blooming gate. When the anti-blooming pulse ends, the block starts clocking out the configured number of pixels at 50% duty. The line finishes with the phases parked again, ready for the next request.

Any count that is smaller than its minimum is raised to that minimum. With the default parameters and a 200 MHz clock, the minimums give at least 100 ns of photo-gate width and at least 750 ns of anti-blooming width.

Top module: `lccd_xfer_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, ph1_o=1, ph2_o=0, and tg_o, pg_o, ab_o, pix_valid_o and line_done_o are all 0.
- R2: During readout, ph2_o is always the inverse of ph1_o. Each phase level lasts exactly H cycles, where H is the clamped half-period.
- R3: Outside readout the phases are parked with ph1_o=1 and ph2_o=0. This includes the whole time tg_o, pg_o or ab_o is high.
- R4: A start that is accepted on edge a makes tg_o rise on edge a+L1, where L1 = max(tg_lead_i, 1).
- R5: pg_o rises L2 = max(pg_lead_i, 1) cycles after tg_o rises. pg_o is never high while tg_o is low.
- R6: pg_o stays high for W = max(pg_width_i, MIN_PG_W) cycles. MIN_PG_W defaults to 20.
- R7: tg_o falls G = max(tg_lag_i, 1) cycles after pg_o falls. The tg_o pulse therefore lasts L2+W+G cycles, which is always more than MIN_PG_W.
- R8: ab_o rises max(ab_lead_i, 1) cycles after tg_o falls. It stays high for max(ab_width_i, MIN_AB_W) cycles, where MIN_AB_W defaults to 150. It is never high together with tg_o.
- R9: Readout begins on the edge where ab_o falls. tg_o stays low throughout readout. ph1_o first falls H cycles after ab_o falls.
- R10: pix_valid_o is a one-cycle pulse on every rising edge of ph1_o during readout. It pulses exactly N = max(npix_i, 1) times per line.
- R11: line_done_o is a one-cycle pulse coincident with the N-th pix_valid_o. The phases stay parked from then until the next line.
- R12: A start request is ignored while a line is in progress, that is, from the accepting edge through the edge that follows line_done_o.
- R13: The half-period is H = max(half_i, MIN_HALF), where MIN_HALF defaults to 3. All settings are sampled only on the accepting edge. Input changes after that edge do not affect the line in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Line request, sampled while idle |
| npix_i | input | 12 | Pixels per line |
| half_i | input | 16 | Cycles per shift-phase half period |
| tg_lead_i | input | 16 | Cycles from accept to transfer gate rise |
| pg_lead_i | input | 16 | Cycles from transfer gate rise to photo gate rise |
| pg_width_i | input | 16 | Photo gate high time in cycles |
| tg_lag_i | input | 16 | Cycles from photo gate fall to transfer gate fall |
| ab_lead_i | input | 16 | Cycles from transfer gate fall to anti-blooming rise |
| ab_width_i | input | 16 | Anti-blooming high time in cycles |
| ph1_o | output | 1 | Horizontal shift phase 1 |
| ph2_o | output | 1 | Horizontal shift phase 2 |
| tg_o | output | 1 | Transfer gate |
| pg_o | output | 1 | Photo gate |
| ab_o | output | 1 | Anti-blooming gate |
| pix_valid_o | output | 1 | One-cycle strobe per pixel |
| line_done_o | output | 1 | One-cycle end-of-line pulse |

## Verification
Suppose the sequencer state or its interval counter is corrupted. The very next gate edge then lands on the wrong cycle, or a gate pulses out of order, so the error shows on tg_o, pg_o or ab_o within one interval of the fault. A wrong half-period counter or pixel counter shows differently: the phases go out of step, or the valid-strobe count and the end-of-line timing are wrong, within one half-period, or at the latest at the end of the line. The bench compares every output on every cycle of each line against a waveform built from the clamped settings. A misplaced edge is therefore caught on the cycle it occurs.

// File: rtl/lccd_pkg.sv
`timescale 1ns/1ps
package lccd_pkg;
    localparam int CNT_W = 16;
    localparam int PIX_W = 12;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [2:0] {
        ST_PARK,
        ST_TG_LEAD,
        ST_PG_LEAD,
        ST_PG_HI,
        ST_TG_LAG,
        ST_AB_LEAD,
        ST_AB_HI,
        ST_READ
    } seq_st_e;

    typedef struct packed {
        cnt_t tg_lead;
        cnt_t pg_lead;
        cnt_t pg_width;
        cnt_t tg_lag;
        cnt_t ab_lead;
        cnt_t ab_width;
        cnt_t half;
        pix_t npix;
    } line_cfg_t;

    function automatic cnt_t floor_cnt(cnt_t v, cnt_t lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic logic st_tg_high(seq_st_e s);
        return (s == ST_PG_LEAD) || (s == ST_PG_HI) || (s == ST_TG_LAG);
    endfunction
endpackage

// File: rtl/lccd_cfg_clamp.sv
`timescale 1ns/1ps
module lccd_cfg_clamp
    import lccd_pkg::*;
#(
    parameter int MIN_HALF = 3,
    parameter int MIN_PG_W = 20,
    parameter int MIN_AB_W = 150
) (
    input  cnt_t      tg_lead_i,
    input  cnt_t      pg_lead_i,
    input  cnt_t      pg_width_i,
    input  cnt_t      tg_lag_i,
    input  cnt_t      ab_lead_i,
    input  cnt_t      ab_width_i,
    input  cnt_t      half_i,
    input  pix_t      npix_i,
    output line_cfg_t cfg_o
);
    localparam cnt_t ONE_C  = cnt_t'(1);
    localparam cnt_t HALF_C = cnt_t'(MIN_HALF);
    localparam cnt_t PGW_C  = cnt_t'(MIN_PG_W);
    localparam cnt_t ABW_C  = cnt_t'(MIN_AB_W);

    always_comb begin
        cfg_o.tg_lead  = floor_cnt(tg_lead_i, ONE_C);
        cfg_o.pg_lead  = floor_cnt(pg_lead_i, ONE_C);
        cfg_o.pg_width = floor_cnt(pg_width_i, PGW_C);
        cfg_o.tg_lag   = floor_cnt(tg_lag_i, ONE_C);
        cfg_o.ab_lead  = floor_cnt(ab_lead_i, ONE_C);
        cfg_o.ab_width = floor_cnt(ab_width_i, ABW_C);
        cfg_o.half     = floor_cnt(half_i, HALF_C);
        cfg_o.npix     = (npix_i == '0) ? pix_t'(1) : npix_i;
    end
endmodule

// File: rtl/lccd_seq.sv
`timescale 1ns/1ps
module lccd_seq
    import lccd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  line_cfg_t cfg_i,
    input  logic      done_i,
    output line_cfg_t cfg_o,
    output logic      read_en_o,
    output logic      tg_o,
    output logic      pg_o,
    output logic      ab_o
);
    seq_st_e   state_q, state_d;
    cnt_t      cnt_q, cnt_d;
    line_cfg_t cfg_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PARK: begin
                if (start_i) begin
                    state_d = ST_TG_LEAD;
                    cnt_d   = cfg_i.tg_lead - 1'b1;
                end
            end
            ST_READ: begin
                if (done_i) state_d = ST_PARK;
            end
            default: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    unique case (state_q)
                        ST_TG_LEAD: begin state_d = ST_PG_LEAD; cnt_d = cfg_q.pg_lead  - 1'b1; end
                        ST_PG_LEAD: begin state_d = ST_PG_HI;   cnt_d = cfg_q.pg_width - 1'b1; end
                        ST_PG_HI:   begin state_d = ST_TG_LAG;  cnt_d = cfg_q.tg_lag   - 1'b1; end
                        ST_TG_LAG:  begin state_d = ST_AB_LEAD; cnt_d = cfg_q.ab_lead  - 1'b1; end
                        ST_AB_LEAD: begin state_d = ST_AB_HI;   cnt_d = cfg_q.ab_width - 1'b1; end
                        default:    begin state_d = ST_READ;    cnt_d = '0; end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PARK;
            cnt_q   <= '0;
            cfg_q   <= '0;
            tg_o    <= 1'b0;
            pg_o    <= 1'b0;
            ab_o    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_PARK && start_i) cfg_q <= cfg_i;
            tg_o    <= st_tg_high(state_d);
            pg_o    <= (state_d == ST_PG_HI);
            ab_o    <= (state_d == ST_AB_HI);
        end
    end

    assign cfg_o     = cfg_q;
    assign read_en_o = (state_q == ST_READ);

    p_pg_in_tg_r5: assert property (@(posedge clk) disable iff (rst)
        pg_o |-> tg_o);
    p_tg_after_pg_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tg_o) |-> !pg_o && !$past(pg_o));
    p_ab_apart_r8: assert property (@(posedge clk) disable iff (rst)
        ab_o |-> !tg_o);
    p_read_gates_low_r9: assert property (@(posedge clk) disable iff (rst)
        read_en_o |-> !tg_o && !pg_o && !ab_o);
endmodule

// File: rtl/lccd_hphase.sv
`timescale 1ns/1ps
module lccd_hphase
    import lccd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  cnt_t half_i,
    input  pix_t npix_i,
    output logic ph1_o,
    output logic ph2_o,
    output logic pix_valid_o,
    output logic line_done_o
);
    cnt_t hcnt_q;
    pix_t pcnt_q;
    pix_t pcnt_nx;

    assign pcnt_nx = pcnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            hcnt_q      <= half_i - 1'b1;
            pcnt_q      <= '0;
            ph1_o       <= 1'b1;
            ph2_o       <= 1'b0;
            pix_valid_o <= 1'b0;
            line_done_o <= 1'b0;
        end else begin
            pix_valid_o <= 1'b0;
            line_done_o <= 1'b0;
            if (hcnt_q == '0) begin
                hcnt_q <= half_i - 1'b1;
                ph1_o  <= ~ph1_o;
                ph2_o  <= ~ph2_o;
                if (!ph1_o) begin
                    pix_valid_o <= 1'b1;
                    pcnt_q      <= pcnt_nx;
                    if (pcnt_nx == npix_i) line_done_o <= 1'b1;
                end
            end else begin
                hcnt_q <= hcnt_q - 1'b1;
            end
        end
    end

    p_compl_r2: assert property (@(posedge clk) disable iff (rst)
        ph1_o != ph2_o);
    p_park_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ph1_o && !ph2_o);
    p_pv_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> ph1_o && !$past(ph1_o));
    p_done_with_pv_r11: assert property (@(posedge clk) disable iff (rst)
        line_done_o |-> pix_valid_o);
endmodule

// File: rtl/lccd_xfer_gen.sv
`timescale 1ns/1ps
module lccd_xfer_gen
    import lccd_pkg::*;
#(
    parameter int MIN_HALF = 3,
    parameter int MIN_PG_W = 20,
    parameter int MIN_AB_W = 150
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [PIX_W-1:0] npix_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic [CNT_W-1:0] tg_lead_i,
    input  logic [CNT_W-1:0] pg_lead_i,
    input  logic [CNT_W-1:0] pg_width_i,
    input  logic [CNT_W-1:0] tg_lag_i,
    input  logic [CNT_W-1:0] ab_lead_i,
    input  logic [CNT_W-1:0] ab_width_i,
    output logic             ph1_o,
    output logic             ph2_o,
    output logic             tg_o,
    output logic             pg_o,
    output logic             ab_o,
    output logic             pix_valid_o,
    output logic             line_done_o
);
    line_cfg_t cfg_raw;
    line_cfg_t cfg_line;
    logic      read_en;

    lccd_cfg_clamp #(
        .MIN_HALF (MIN_HALF),
        .MIN_PG_W (MIN_PG_W),
        .MIN_AB_W (MIN_AB_W)
    ) clamp_i (
        .tg_lead_i  (tg_lead_i),
        .pg_lead_i  (pg_lead_i),
        .pg_width_i (pg_width_i),
        .tg_lag_i   (tg_lag_i),
        .ab_lead_i  (ab_lead_i),
        .ab_width_i (ab_width_i),
        .half_i     (half_i),
        .npix_i     (npix_i),
        .cfg_o      (cfg_raw)
    );

    lccd_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cfg_i     (cfg_raw),
        .done_i    (line_done_o),
        .cfg_o     (cfg_line),
        .read_en_o (read_en),
        .tg_o      (tg_o),
        .pg_o      (pg_o),
        .ab_o      (ab_o)
    );

    lccd_hphase hphase_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (read_en),
        .half_i      (cfg_line.half),
        .npix_i      (cfg_line.npix),
        .ph1_o       (ph1_o),
        .ph2_o       (ph2_o),
        .pix_valid_o (pix_valid_o),
        .line_done_o (line_done_o)
    );

    p_park_in_xfer_r3: assert property (@(posedge clk) disable iff (rst)
        (tg_o || pg_o || ab_o) |-> ph1_o && !ph2_o);
endmodule

// File: tb/lccd_xfer_gen_tb_top.sv
`timescale 1ns/1ps
module lccd_xfer_gen_tb_top;
    import lccd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    pix_t np_i = '0;
    cnt_t hf_i = '0, tgl_i = '0, pgl_i = '0, pgw_i = '0, tgg_i = '0, abl_i = '0, abw_i = '0;
    logic ph1, ph2, tg, pg, ab, pv, done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lccd_xfer_gen dut_i (
        .clk(clk), .rst(rst), .start_i(start), .npix_i(np_i), .half_i(hf_i),
        .tg_lead_i(tgl_i), .pg_lead_i(pgl_i), .pg_width_i(pgw_i), .tg_lag_i(tgg_i),
        .ab_lead_i(abl_i), .ab_width_i(abw_i),
        .ph1_o(ph1), .ph2_o(ph2), .tg_o(tg), .pg_o(pg), .ab_o(ab),
        .pix_valid_o(pv), .line_done_o(done)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

    // expected waveform state, set per line
    int T1, T2, T3, T4, T5, T6, H, N;
    int bad_k[7];
    int bad_a[7];
    int bad_e[7];

    function automatic bit x_tg(input int k); return k >= T1 && k < T4; endfunction
    function automatic bit x_pg(input int k); return k >= T2 && k < T3; endfunction
    function automatic bit x_ab(input int k); return k >= T5 && k < T6; endfunction
    function automatic bit x_ph1(input int k);
        int j;
        if (k < T6) return 1'b1;
        j = k - T6;
        if (j >= 2*N*H) return 1'b1;
        return ((j / H) % 2) == 0;
    endfunction
    function automatic bit x_pv(input int k);
        int j;
        j = k - T6;
        return j > 0 && j <= 2*N*H && (j % (2*H)) == 0;
    endfunction
    function automatic bit x_done(input int k); return (k - T6) == 2*N*H; endfunction

    task automatic cmp(input int idx, input bit act, input bit exp, input int k);
        if (act !== exp && bad_k[idx] < 0) begin
            bad_k[idx] = k; bad_a[idx] = int'(act); bad_e[idx] = int'(exp);
        end
    endtask

    task automatic run_line(input int tgl, input int pgl, input int pgw, input int tgg,
                            input int abl, input int abw, input int hf, input int np, input bit inject);
        int kmax, inj, pv_cnt;
        @(negedge clk);
        tgl_i = cnt_t'(tgl); pgl_i = cnt_t'(pgl); pgw_i = cnt_t'(pgw); tgg_i = cnt_t'(tgg);
        abl_i = cnt_t'(abl); abw_i = cnt_t'(abw); hf_i = cnt_t'(hf); np_i = pix_t'(np);
        start = 1'b1;
        T1 = clampi(tgl, 1);
        T2 = T1 + clampi(pgl, 1);
        T3 = T2 + clampi(pgw, 20);
        T4 = T3 + clampi(tgg, 1);
        T5 = T4 + clampi(abl, 1);
        T6 = T5 + clampi(abw, 150);
        H  = clampi(hf, 3);
        N  = clampi(np, 1);
        kmax = T6 + 2*N*H + 3;
        inj = inject ? $urandom_range(T6 + 2*N*H - 1, 0) : -1;
        for (int i = 0; i < 7; i++) bad_k[i] = -1;
        pv_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        // R13: scramble settings after acceptance
        tgl_i = cnt_t'($urandom_range(9, 0)); pgl_i = cnt_t'($urandom_range(9, 0));
        pgw_i = cnt_t'($urandom_range(60, 0)); tgg_i = cnt_t'($urandom_range(9, 0));
        abl_i = cnt_t'($urandom_range(9, 0)); abw_i = cnt_t'($urandom_range(200, 0));
        hf_i  = cnt_t'($urandom_range(9, 0)); np_i = pix_t'($urandom_range(20, 0));
        for (int k = 0; k <= kmax; k++) begin
            cmp(0, tg, x_tg(k), k);
            cmp(1, pg, x_pg(k), k);
            cmp(2, ab, x_ab(k), k);
            cmp(3, ph1, x_ph1(k), k);
            cmp(4, ph2, !x_ph1(k), k);
            cmp(5, pv, x_pv(k), k);
            cmp(6, done, x_done(k), k);
            if (pv === 1'b1) pv_cnt++;
            start = (k == inj); // R12: request during a busy line
            @(negedge clk);
        end
        start = 1'b0;
        check(bad_k[0] < 0, "R4/R7", $sformatf("tg_o at k=%0d", bad_k[0]), bad_a[0], bad_e[0]);
        check(bad_k[1] < 0, "R5/R6", $sformatf("pg_o at k=%0d", bad_k[1]), bad_a[1], bad_e[1]);
        check(bad_k[2] < 0, "R8", $sformatf("ab_o at k=%0d", bad_k[2]), bad_a[2], bad_e[2]);
        check(bad_k[3] < 0, "R2/R3/R9/R12/R13", $sformatf("ph1_o at k=%0d", bad_k[3]), bad_a[3], bad_e[3]);
        check(bad_k[4] < 0, "R2", $sformatf("ph2_o at k=%0d", bad_k[4]), bad_a[4], bad_e[4]);
        check(bad_k[5] < 0, "R10", $sformatf("pix_valid_o at k=%0d", bad_k[5]), bad_a[5], bad_e[5]);
        check(bad_k[6] < 0, "R11", $sformatf("line_done_o at k=%0d", bad_k[6]), bad_a[6], bad_e[6]);
        check(pv_cnt == N, "R10", "pixel strobes per line", pv_cnt, N);
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;
        @(negedge clk);
        check(ph1 === 1'b1 && ph2 === 1'b0, "R1", "phases in reset", {30'd0, ph1, ph2}, 2);
        check({tg, pg, ab, pv, done} === 5'b0, "R1", "gates and strobes in reset", int'({tg, pg, ab, pv, done}), 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ph1 === 1'b1 && ph2 === 1'b0 && {tg, pg, ab, pv, done} === 5'b0, "R1",
              "idle after reset", int'({ph1, ph2, tg, pg, ab, pv, done}), 64);
        // directed: everything zero, clamps engage (R13)
        run_line(0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        // directed: every setting exactly at its minimum
        run_line(1, 1, 20, 1, 1, 150, 3, 1, 1'b1);
        // directed: just below minimum widths
        run_line(2, 1, 19, 1, 1, 149, 2, 2, 1'b0);
        // directed: longer line with a busy start injected
        run_line(5, 3, 40, 4, 2, 160, 6, 12, 1'b1);
        for (int n = 0; n < 24; n++) begin
            run_line($urandom_range(4, 0), $urandom_range(3, 0), $urandom_range(40, 10),
                     $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(170, 140),
                     $urandom_range(6, 1), $urandom_range(12, 0), 1'($urandom_range(1, 0)));
        end
        // R3/R11: no request, phases stay parked and gates low
        for (int k = 0; k < 20; k++) begin
            start = 1'b0;
            @(negedge clk);
            if (k == 19)
                check(ph1 === 1'b1 && ph2 === 1'b0 && {tg, pg, ab, pv} === 4'b0, "R3",
                      "idle park", int'({ph1, ph2, tg, pg, ab, pv}), 32);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule